// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block sits in a synchronous DRAM controller and keeps the memory's refresh coverage intact. A free-running interval timer adds one unit of refresh debt each time a programmable number of clock cycles passes. With the default of 1562 cycles at 100 MHz, that is one refresh every 15.6 us, which meets the 4096-refreshes-per-64-ms budget. Whenever debt is outstanding, the scheduler raises a request to the command arbiter upstream. That arbiter has already closed every open bank before it answers with a grant.

On an accepted grant, the block drives the auto-refresh command for exactly one cycle. That command is chip select low, row and column strobes low, write enable high and clock enable high. It carries no address, because the memory generates the refresh row itself. At the same edge the block opens a busy window that covers the refresh-to-activate time: 7 cycles by default, for 70 ns at a 10 ns clock. When the window closes, every bank is idle and the next command may activate any bank.

Refreshes can be postponed. Debt accumulates up to a ceiling. When the debt reaches the urgency level, an urgent flag tells the arbiter to put refresh ahead of normal traffic. If a refresh interval expires while the debt is already at its ceiling, that interval is lost and a one-cycle pulse reports it.

Top module: `sdr_refresh_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the outputs are as follows. Request, urgent, busy and dropped are all 0. Debt is 0. The command outputs show deselect: chip select, row strobe, column strobe and write enable all 1, and clock enable 1.
- R2: Refresh debt rises by one at every INTERVAL-th rising clock edge counted from reset release, and at no other edge. The first rise happens at edge INTERVAL.
- R3: The request output is 1 exactly when debt is nonzero and busy is 0.
- R4: A grant sampled while the request is 1 produces the auto-refresh command on the following cycle only. The command is {cs_n, ras_n, cas_n, we_n, cke} = 5'b00011. In every other cycle the command outputs show deselect (5'b11111).
- R5: A grant sampled while the request is 0 has no effect: no command is issued and the debt is unchanged.
- R6: Busy is 1 for exactly BUSY_CYCLES cycles, starting with the cycle that shows the refresh command. While busy is 1, the request is 0 and a held grant issues no command.
- R7: An accepted grant lowers the debt by one. If an interval expiry and an accepted grant fall on the same edge, the debt is left unchanged.
- R8: The urgent output is 1 exactly when debt is at least URGENT_LEVEL and busy is 0.
- R9: Debt never exceeds DEBT_MAX. When an interval expires at DEBT_MAX with no accepted grant on that edge, the debt stays at DEBT_MAX and the dropped output pulses 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_grant | input | 1 | Arbiter grant, acted on only while the request is high |
| refresh_req | output | 1 | Refresh wanted: debt outstanding and not busy |
| refresh_urgent | output | 1 | Debt has reached the urgency level; refresh should preempt traffic |
| refresh_busy | output | 1 | Refresh-to-activate window in progress; no other command allowed |
| refresh_debt | output | $clog2(DEBT_MAX+1) | Number of refreshes owed |
| refresh_dropped | output | 1 | One-cycle pulse when an interval expired with the debt at its ceiling |
| sdr_cs_n | output | 1 | Chip select to the memory, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_cke | output | 1 | Clock enable, held high |

## Verification
Some properties are checked by the assertions on every cycle:
- a refresh command never lasts longer than one cycle and always falls inside the busy window;
- a grant is never accepted while the window is open;
- the debt never falls below zero and moves by at most one step per edge;
- interval ticks never come back to back;
- urgent never appears without a request.

Other properties need the bench's directed scenarios, which count edges from reset release:
- the exact edge at which debt first rises;
- the length of the busy window;
- that an ignored grant really leaves debt and command lines alone;
- that a tick and a grant on the same edge cancel;
- the saturation and dropped pulse at the debt ceiling.

// File: rtl/sdr_refresh_pkg.sv
package sdr_refresh_pkg;

   // Command pins driven toward the memory, in a fixed packed order.
   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic cke;
   } sdr_cmd_t;

   localparam sdr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                     we_n: 1'b1, cke: 1'b1};

   localparam sdr_cmd_t CMD_AUTOREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0,
                                       we_n: 1'b1, cke: 1'b1};

   function automatic logic cmd_is_autoref(sdr_cmd_t c);
      return (c == CMD_AUTOREF);
   endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int unsigned INTERVAL = 1562
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW      = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);
   localparam bit          IS_POW2 = ((INTERVAL & (INTERVAL - 1)) == 0);
   localparam logic [CW-1:0] LAST  = CW'(INTERVAL - 1);

   initial begin : chk_params
      assert (INTERVAL >= 2)
         else $fatal(1, "rfs_interval_timer: INTERVAL must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   generate
      if (IS_POW2) begin : g_wrap
         // Power-of-two spacing: the counter wraps by itself.
         always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign tick = &cnt_q;
      end else begin : g_cmp
         // Any other spacing: compare against the last count and clear.
         always_ff @(posedge clk) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate

   // Two ticks can never fall on consecutive edges.
   p_tick_gap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/rfs_debt_counter.sv
module rfs_debt_counter #(
   parameter int unsigned DEBT_MAX = 8,
   localparam int unsigned DW      = $clog2(DEBT_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [DW-1:0] debt,
   output logic          dropped
);
   localparam logic [DW-1:0] CEIL = DW'(DEBT_MAX);

   initial begin : chk_params
      assert (DEBT_MAX >= 1)
         else $fatal(1, "rfs_debt_counter: DEBT_MAX must be at least 1");
   end

   logic [DW-1:0] debt_q;
   logic          drop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         debt_q <= '0;
         drop_q <= 1'b0;
      end else begin
         drop_q <= 1'b0;
         if (inc && !dec) begin
            if (debt_q == CEIL) drop_q <= 1'b1;
            else                debt_q <= debt_q + 1'b1;
         end else if (dec && !inc) begin
            debt_q <= debt_q - 1'b1;
         end
      end
   end

   assign debt    = debt_q;
   assign dropped = drop_q;

   // The issuing side may only retire a refresh that is owed.
   p_dec_owed_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (debt_q != '0));

   // The debt moves by one step at most per edge.
   p_debt_step_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (debt_q == $past(debt_q)) || (debt_q == $past(debt_q) + 1'b1) ||
      (debt_q == $past(debt_q) - 1'b1));

   p_debt_ceiling_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      drop_q |-> (debt_q == CEIL));

endmodule

// File: rtl/rfs_busy_window.sv
module rfs_busy_window #(
   parameter int unsigned BUSY_CYCLES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);
   localparam logic [BW-1:0] LOAD = BW'(BUSY_CYCLES);

   initial begin : chk_params
      assert (BUSY_CYCLES >= 1)
         else $fatal(1, "rfs_busy_window: BUSY_CYCLES must be at least 1");
   end

   logic [BW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            left_q <= '0;
      else if (start)        left_q <= LOAD;
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

   // A new window is never opened while one is running.
   p_start_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // A window only opens in response to a start.
   p_busy_opens_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
   import sdr_refresh_pkg::*;
#(
   parameter int unsigned INTERVAL     = 1562,
   parameter int unsigned BUSY_CYCLES  = 7,
   parameter int unsigned DEBT_MAX     = 8,
   parameter int unsigned URGENT_LEVEL = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            refresh_grant,
   output logic                            refresh_req,
   output logic                            refresh_urgent,
   output logic                            refresh_busy,
   output logic [$clog2(DEBT_MAX+1)-1:0]   refresh_debt,
   output logic                            refresh_dropped,
   output logic                            sdr_cs_n,
   output logic                            sdr_ras_n,
   output logic                            sdr_cas_n,
   output logic                            sdr_we_n,
   output logic                            sdr_cke
);
   localparam int unsigned DW = $clog2(DEBT_MAX + 1);
   localparam logic [DW-1:0] URGENT_AT = DW'(URGENT_LEVEL);

   initial begin : chk_params
      assert (URGENT_LEVEL >= 1 && URGENT_LEVEL <= DEBT_MAX)
         else $fatal(1, "sdr_refresh_sched: URGENT_LEVEL out of 1..DEBT_MAX");
      assert (BUSY_CYCLES < INTERVAL)
         else $fatal(1, "sdr_refresh_sched: busy window must fit in an interval");
   end

   logic          tick;
   logic          busy;
   logic          accept;
   logic [DW-1:0] debt;
   logic          dropped;
   sdr_cmd_t      cmd_q;

   rfs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   rfs_debt_counter #(.DEBT_MAX(DEBT_MAX)) u_debt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (tick),
      .dec     (accept),
      .debt    (debt),
      .dropped (dropped)
   );

   rfs_busy_window #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .busy  (busy)
   );

   assign refresh_req    = (debt != '0) && !busy;
   assign refresh_urgent = (debt >= URGENT_AT) && !busy;
   assign accept         = refresh_grant && refresh_req;

   // Registered command stage: auto-refresh for one cycle after acceptance.
   always_ff @(posedge clk) begin
      if (!rst_n)      cmd_q <= CMD_DESEL;
      else if (accept) cmd_q <= CMD_AUTOREF;
      else             cmd_q <= CMD_DESEL;
   end

   assign refresh_busy    = busy;
   assign refresh_debt    = debt;
   assign refresh_dropped = dropped;
   assign sdr_cs_n        = cmd_q.cs_n;
   assign sdr_ras_n       = cmd_q.ras_n;
   assign sdr_cas_n       = cmd_q.cas_n;
   assign sdr_we_n        = cmd_q.we_n;
   assign sdr_cke         = cmd_q.cke;

   // The refresh command lasts a single cycle.
   p_cmd_single_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_is_autoref(cmd_q) |=> !cmd_is_autoref(cmd_q));

   // The refresh command always sits inside the busy window.
   p_cmd_in_busy_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_is_autoref(cmd_q) |-> busy);

   // Urgency is only ever shown alongside a live request.
   p_urgent_req_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      refresh_urgent |-> refresh_req);

   // Clock enable is never dropped by this block.
   p_cke_high_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      sdr_cke);

endmodule

// File: tb/sdr_refresh_sched_bench.sv
module sdr_refresh_sched_bench;
   localparam int CLK_PERIOD = 10;
   localparam int INTERVAL   = 20;
   localparam int BUSY       = 7;
   localparam int DMAX       = 8;
   localparam int URG        = 8;
   localparam int DW         = $clog2(DMAX + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          grant = 1'b0;
   logic          req, urgent, busy, dropped;
   logic [DW-1:0] debt;
   logic          cs_n, ras_n, cas_n, we_n, cke;

   int n_vec = 0;
   int n_bad = 0;
   int edge_n = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

   sdr_refresh_sched #(
      .INTERVAL(INTERVAL), .BUSY_CYCLES(BUSY),
      .DEBT_MAX(DMAX), .URGENT_LEVEL(URG)
   ) u_sdr_refresh_sched (
      .clk(clk), .rst_n(rst_n), .refresh_grant(grant),
      .refresh_req(req), .refresh_urgent(urgent), .refresh_busy(busy),
      .refresh_debt(debt), .refresh_dropped(dropped),
      .sdr_cs_n(cs_n), .sdr_ras_n(ras_n), .sdr_cas_n(cas_n),
      .sdr_we_n(we_n), .sdr_cke(cke)
   );

   function automatic logic [4:0] cmd_bits();
      return {cs_n, ras_n, cas_n, we_n, cke};
   endfunction

   task automatic chk(input string tag, input string what,
                      input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s at edge %0d: actual %0d expected %0d",
                  tag, what, edge_n, act, exp);
      end
   endtask

   task automatic goto_edge(input int k);
      while (edge_n < k) @(negedge clk);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R1", "req in reset", req, 0);
      chk("R1", "busy in reset", busy, 0);
      chk("R1", "debt in reset", debt, 0);
      chk("R1", "cmd in reset", cmd_bits(), 5'b11111);
      rst_n = 1'b1;
      goto_edge(1);
      chk("R1", "urgent after reset", urgent, 0);
      chk("R1", "dropped after reset", dropped, 0);
      chk("R1", "cmd after reset", cmd_bits(), 5'b11111);
   endtask

   task automatic t_interval;
      goto_edge(INTERVAL - 1);
      chk("R2", "debt before first tick", debt, 0);
      chk("R3", "req with no debt", req, 0);
      goto_edge(INTERVAL);
      chk("R2", "debt after first tick", debt, 1);
      chk("R3", "req with debt", req, 1);
      chk("R8", "urgent at low debt", urgent, 0);
   endtask

   task automatic t_grant_busy;
      grant = 1'b1;
      goto_edge(21);
      grant = 1'b0;
      chk("R4", "refresh command", cmd_bits(), 5'b00011);
      chk("R6", "busy on command", busy, 1);
      chk("R7", "debt after grant", debt, 0);
      chk("R3", "req while busy", req, 0);
      goto_edge(22);
      chk("R4", "command one cycle", cmd_bits(), 5'b11111);
      for (int k = 22; k <= 27; k++) begin
         goto_edge(k);
         chk("R6", "busy inside window", busy, 1);
      end
      goto_edge(28);
      chk("R6", "busy after window", busy, 0);
   endtask

   task automatic t_grant_ignored;
      grant = 1'b1;
      for (int k = 29; k <= 35; k++) begin
         goto_edge(k);
         chk("R5", "cmd on idle grant", cmd_bits(), 5'b11111);
         chk("R5", "debt on idle grant", debt, 0);
      end
      grant = 1'b0;
   endtask

   task automatic t_busy_blocks;
      goto_edge(59);
      chk("R2", "debt after second tick", debt, 1);
      goto_edge(60);
      chk("R2", "debt after third tick", debt, 2);
      grant = 1'b1;
      goto_edge(61);
      chk("R4", "first command", cmd_bits(), 5'b00011);
      chk("R7", "debt after first grant", debt, 1);
      chk("R6", "req masked by busy", req, 0);
      for (int k = 62; k <= 67; k++) begin
         goto_edge(k);
         chk("R6", "no cmd while busy", cmd_bits(), 5'b11111);
         chk("R6", "debt held while busy", debt, 1);
      end
      goto_edge(68);
      chk("R6", "window closed", busy, 0);
      chk("R3", "req after window", req, 1);
      goto_edge(69);
      grant = 1'b0;
      chk("R4", "second command", cmd_bits(), 5'b00011);
      chk("R7", "debt after second grant", debt, 0);
   endtask

   task automatic t_tick_and_grant;
      goto_edge(100);
      chk("R2", "debt before combined edge", debt, 2);
      goto_edge(119);
      grant = 1'b1;
      goto_edge(120);
      grant = 1'b0;
      chk("R7", "tick plus grant debt", debt, 2);
      chk("R4", "command on combined edge", cmd_bits(), 5'b00011);
   endtask

   task automatic t_urgent_saturate;
      goto_edge(239);
      chk("R2", "debt at seven", debt, 7);
      chk("R8", "urgent below level", urgent, 0);
      goto_edge(240);
      chk("R8", "urgent at level", urgent, 1);
      chk("R9", "debt at ceiling", debt, 8);
      goto_edge(259);
      chk("R9", "no drop before expiry", dropped, 0);
      goto_edge(260);
      chk("R9", "drop pulse", dropped, 1);
      chk("R9", "debt saturated", debt, 8);
      goto_edge(261);
      chk("R9", "drop pulse ends", dropped, 0);
      grant = 1'b1;
      goto_edge(262);
      grant = 1'b0;
      chk("R4", "command from ceiling", cmd_bits(), 5'b00011);
      chk("R7", "debt below ceiling", debt, 7);
      chk("R8", "urgent cleared", urgent, 0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_interval();
      t_grant_busy();
      t_grant_ignored();
      t_busy_blocks();
      t_tick_and_grant();
      t_urgent_saturate();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule